// File: doc/BRIEF.md
# Way-Concatenating Configurable Read Cache

This block is an 8 KB read-only cache. Its storage is four equal banks of 64 lines, and each line holds 32 bytes. A run-time setting decides how that storage is organised: four ways, two ways, or one way. In the narrower modes, the two address bits just above the line index stop acting only as tag bits and also steer the access to a particular bank. Every line is tagged with the same 21 upper address bits in every mode, so the tag width never changes. A bank-enable mask can also switch whole banks off. A switched-off bank is never read and never filled, which shrinks the cache.

The processor side presents a word address with a request strobe. A hit returns the word one cycle after acceptance, with a hit flag. A miss raises a line-fill request toward the next memory level and takes in eight words. It stores the line in a bank chosen by a per-set round-robin pointer, then returns the requested word. While a fill is in progress the block holds off new requests. The block drives a bank-enable vector during each lookup, which shows the number of banks read per access and so exposes the energy cost of each mode.

Top module: `waycat_cache`

## Requirements
- R1: Mode code 0 (four-way): every switched-on bank is a candidate. Up to four lines that share an index can be resident at the same time, and `bank_en` equals the switched-on mask during an accepted request.
- R2: Mode code 1 (two-way): the candidates are the switched-on banks whose bank number has bit 0 equal to address bit 11, that is banks {0,2} or banks {1,3}.
- R3: Mode codes 2 and 3 (one-way): the single candidate is the bank numbered by address bits 12:11, provided that bank is switched on.
- R4: On a miss, `fill_req` rises with `fill_addr` equal to the request address with bits 4:0 cleared. It stays steady until eight words have arrived, which may come with gaps. The words are taken in ascending order. The response then carries `rsp_hit`=0 and the requested word, selected by address bits 4:2.
- R5: A hit raises `rsp_valid` with `rsp_hit`=1 and the stored word in the cycle after the request is accepted.
- R6: Replacement uses a per-set pointer. The victim is the first candidate bank at or after the pointer, counting in ascending order with wrap-around. The pointer then moves to the victim plus one. Pointers start at bank 0.
- R7: A bank whose bit in `cfg_bank_on` is 0 never appears in `bank_en` and never receives a line. A request whose candidate set is empty is fetched and returned with `rsp_hit`=0, but it is not stored.
- R8: A configuration write is taken while no fill is running. It invalidates every line and resets every pointer to bank 0. `req_ready` is low in the cycle the write is presented.
- R9: `req_ready` is low from the cycle after a miss is accepted until the cycle after the last fill word. A request held during this time is accepted once `req_ready` returns.
- R10: After reset the mode is four-way, all banks are switched on, no line is valid, `req_ready`=1, and `fill_req`, `rsp_valid` and `bank_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Associativity code: 0 four-way, 1 two-way, 2/3 one-way |
| cfg_bank_on | input | 4 | Per-bank switch-on mask |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address of the requested word |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Response came from a resident line |
| rsp_data | output | 32 | Returned word |
| fill_req | output | 1 | Line fill in progress |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_valid | input | 1 | Fill word strobe |
| fill_data | input | 32 | Fill word, in ascending order |
| bank_en | output | 4 | Banks read by the current lookup |

## Verification
Two things can coincide in one cycle: the completion of a line fill and a request that has been waiting for it. The bench provokes this by holding `req_valid` high, with an address in the same line, across a whole fill that includes a gap in the word stream. The behavioural model requires `req_ready` to stay low on every fill cycle. The first request must then complete as a miss with the right word. The held request must be accepted only after that and must hit on the line that was just written.

// File: rtl/waycat_pkg.sv
package waycat_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int NBANK      = 4;
    localparam int SETS       = 64;
    localparam int LINE_WORDS = 8;

    localparam int BYTE_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = BYTE_W + WSEL_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int BSEL_W  = $clog2(NBANK);
    localparam int TAG_LSB = OFF_W + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    typedef enum logic [1:0] {
        MODE_4W  = 2'd0,
        MODE_2W  = 2'd1,
        MODE_1W  = 2'd2,
        MODE_1WB = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;

    // word address split into its cache roles
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
    } waddr_t;

    // candidate banks for a mode; sel are the tag bits just above the index
    function automatic logic [NBANK-1:0] cand_banks(mode_e m, logic [BSEL_W-1:0] sel);
        logic [NBANK-1:0] c;
        logic [BSEL_W-1:0] bb;
        c = '0;
        for (int b = 0; b < NBANK; b++) begin
            bb = BSEL_W'(b);
            case (m)
                MODE_4W: c[b] = 1'b1;
                MODE_2W: c[b] = (bb[0] == sel[0]);
                default: c[b] = (bb == sel);
            endcase
        end
        return c;
    endfunction

    // first candidate at or after the pointer, wrapping
    function automatic logic [BSEL_W-1:0] rr_pick(logic [NBANK-1:0] c, logic [BSEL_W-1:0] ptr);
        logic [BSEL_W-1:0] v;
        logic [BSEL_W-1:0] b;
        logic found;
        v = ptr;
        found = 1'b0;
        for (int k = 0; k < NBANK; k++) begin
            b = ptr + BSEL_W'(k);
            if (!found && c[b]) begin
                v = b;
                found = 1'b1;
            end
        end
        return v;
    endfunction
endpackage

// File: rtl/waycat_cfg.sv
module waycat_cfg
    import waycat_pkg::*;
#(
    parameter int NB = NBANK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode_in,
    input  logic [NB-1:0] cfg_on_in,
    input  logic          idle,
    output mode_e         mode_q,
    output logic [NB-1:0] on_q,
    output logic          flush
);
    assign flush = cfg_we && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_4W;
            on_q   <= '1;
        end else if (flush) begin
            mode_q <= mode_e'(cfg_mode_in);
            on_q   <= cfg_on_in;
        end
    end
endmodule

// File: rtl/waycat_tags.sv
module waycat_tags
    import waycat_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int NS = SETS,
    parameter int TW = TAG_W,
    parameter int IW = IDX_W,
    parameter int BW = BSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [IW-1:0] lk_idx,
    input  logic [TW-1:0] lk_tag,
    input  logic [NB-1:0] lk_cand,
    output logic          lk_hit,
    output logic [BW-1:0] lk_bank,
    output logic [BW-1:0] lk_victim,
    input  logic          al_we,
    input  logic [BW-1:0] al_bank,
    input  logic [IW-1:0] al_idx,
    input  logic [TW-1:0] al_tag
);
    logic [NB-1:0] hit_vec;
    logic [BW-1:0] rr_q [NS];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [NS-1:0] vld_q;
        logic [TW-1:0] tag_q [NS];

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld_q <= '0;
            end else if (al_we && al_bank == BW'(b)) begin
                vld_q[al_idx] <= 1'b1;
                tag_q[al_idx] <= al_tag;
            end
        end

        assign hit_vec[b] = lk_cand[b] && vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    always_comb begin
        lk_bank = '0;
        for (int b = 0; b < NB; b++) begin
            if (hit_vec[b]) lk_bank = BW'(b);
        end
    end
    assign lk_hit    = |hit_vec;
    assign lk_victim = rr_pick(lk_cand, rr_q[lk_idx]);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < NS; s++) rr_q[s] <= '0;
        end else if (al_we) begin
            rr_q[al_idx] <= al_bank + 1'b1;
        end
    end

    // R1
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst) flush |=> !lk_hit);
    // R6
    victim_cand_chk: assert property (@(posedge clk) disable iff (rst) (|lk_cand) |-> lk_cand[lk_victim]);
endmodule

// File: rtl/waycat_data.sv
module waycat_data
    import waycat_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int NS = SETS,
    parameter int LW = LINE_WORDS,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = NB * NS * LW;
    localparam int AW    = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/waycat_cache.sv
module waycat_cache
    import waycat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic [NBANK-1:0]  cfg_bank_on,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_data,
    output logic [NBANK-1:0]  bank_en
);
    localparam int DAW = BSEL_W + IDX_W + WSEL_W;
    localparam logic [WSEL_W-1:0] LAST = WSEL_W'(LINE_WORDS - 1);

    fsm_e              st_q;
    waddr_t            cur, pend_q;
    mode_e             mode_q;
    logic [NBANK-1:0]  on_q, cand;
    logic              flush, idle, accept;
    logic              lk_hit;
    logic [BSEL_W-1:0] lk_bank, lk_victim, vict_q;
    logic              alloc_q, al_we, dwe;
    logic [WSEL_W-1:0] wcnt_q;
    logic [WORD_W-1:0] keep_q, rd_word;
    logic              rsp_valid_q, rsp_hit_q;
    logic [WORD_W-1:0] rsp_data_q;
    logic              unused_ok;

    assign cur       = waddr_t'(req_addr[ADDR_W-1:BYTE_W]);
    assign unused_ok = ^req_addr[BYTE_W-1:0];
    assign idle      = (st_q == ST_IDLE);
    assign req_ready = idle && !cfg_we;
    assign accept    = req_valid && req_ready;
    assign cand      = cand_banks(mode_q, cur.tag[BSEL_W-1:0]) & on_q;
    assign bank_en   = accept ? cand : '0;

    waycat_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_mode_in (cfg_mode),
        .cfg_on_in   (cfg_bank_on),
        .idle        (idle),
        .mode_q      (mode_q),
        .on_q        (on_q),
        .flush       (flush)
    );

    assign dwe   = (st_q == ST_FILL) && fill_valid && alloc_q;
    assign al_we = dwe && (wcnt_q == LAST);

    waycat_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_idx    (cur.idx),
        .lk_tag    (cur.tag),
        .lk_cand   (cand),
        .lk_hit    (lk_hit),
        .lk_bank   (lk_bank),
        .lk_victim (lk_victim),
        .al_we     (al_we),
        .al_bank   (vict_q),
        .al_idx    (pend_q.idx),
        .al_tag    (pend_q.tag)
    );

    waycat_data u_data (
        .clk   (clk),
        .we    (dwe),
        .waddr (DAW'({vict_q, pend_q.idx, wcnt_q})),
        .wdata (fill_data),
        .raddr (DAW'({lk_bank, cur.idx, cur.wsel})),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pend_q      <= '0;
            vict_q      <= '0;
            alloc_q     <= 1'b0;
            wcnt_q      <= '0;
            keep_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            rsp_data_q  <= rd_word;
                        end else begin
                            st_q    <= ST_FILL;
                            pend_q  <= cur;
                            vict_q  <= lk_victim;
                            alloc_q <= |cand;
                            wcnt_q  <= '0;
                        end
                    end
                end
                default: begin
                    if (fill_valid) begin
                        wcnt_q <= wcnt_q + 1'b1;
                        if (wcnt_q == pend_q.wsel) keep_q <= fill_data;
                        if (wcnt_q == LAST) begin
                            st_q        <= ST_IDLE;
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b0;
                            rsp_data_q  <= (pend_q.wsel == LAST) ? fill_data : keep_q;
                        end
                    end
                end
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_data  = rsp_data_q;
    assign fill_req  = (st_q == ST_FILL);
    assign fill_addr = {pend_q.tag, pend_q.idx, {OFF_W{1'b0}}};

    // R9
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst) fill_req |-> !req_ready);
    // R5
    hit_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && lk_hit) |=> (rsp_valid && rsp_hit));
    // R4
    fill_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && $past(fill_req)) |-> $stable(fill_addr));
    // R2
    two_way_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_q == MODE_2W) |-> ($countones(bank_en) <= 2));
    // R3
    one_way_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (mode_q == MODE_1W || mode_q == MODE_1WB)) |-> $onehot0(bank_en));
    // R7
    alloc_live_chk: assert property (@(posedge clk) disable iff (rst) al_we |-> on_q[vict_q]);
endmodule

// File: tb/waycat_cache_tb_top.sv
module waycat_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [3:0]  cfg_bank_on = 4'hF;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_data;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic [3:0]  bank_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_fill = '0;

    // behavioural reference state
    bit          mv [4][64];
    logic [20:0] mt [4][64];
    int          mrr [64];
    int          mmode = 0;
    logic [3:0]  mon = 4'hF;

    always #5 clk = ~clk;

    waycat_cache dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_bank_on(cfg_bank_on),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_data(fill_data), .bank_en(bank_en)
    );

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return ({2'b00, a[31:2]} * 32'h9E37_79B1) ^ 32'h3C5A_96E1;
    endfunction

    function automatic logic [3:0] exp_cand(logic [31:0] a);
        logic [3:0] c;
        int sel;
        sel = int'(a[12:11]);
        for (int b = 0; b < 4; b++) begin
            if (mmode == 0)      c[b] = 1'b1;
            else if (mmode == 1) c[b] = ((b % 2) == (sel % 2));
            else                 c[b] = (b == sel);
        end
        return c & mon;
    endfunction

    function automatic bit model_hit(logic [31:0] a);
        logic [3:0] c;
        bit h;
        c = exp_cand(a);
        h = 0;
        for (int b = 0; b < 4; b++)
            if (c[b] && mv[b][int'(a[10:5])] && mt[b][int'(a[10:5])] == a[31:11]) h = 1;
        return h;
    endfunction

    task automatic model_alloc(logic [31:0] a);
        logic [3:0] c;
        int idx;
        int v;
        c = exp_cand(a);
        idx = int'(a[10:5]);
        if (c == 4'h0) return;
        v = -1;
        for (int k = 0; k < 4; k++) begin
            int b;
            b = (mrr[idx] + k) % 4;
            if (v < 0 && c[b]) v = b;
        end
        mv[v][idx] = 1;
        mt[v][idx] = a[31:11];
        mrr[idx] = (v + 1) % 4;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // next-level memory: one idle cycle, a gap before word 3
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req && !fill_valid) begin
                last_fill = fill_addr;
                @(negedge clk);
                for (int k = 0; k < 8; k++) begin
                    if (k == 3) begin
                        fill_valid = 1'b0;
                        @(negedge clk);
                    end
                    fill_valid = 1'b1;
                    fill_data  = mem_word(last_fill + 32'(4 * k));
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    // per-clock comparison: no request may be taken while a fill runs (R9)
    always @(negedge clk) begin
        if (!rst && fill_req) chk("R9", "ready while filling", 64'(req_ready), 64'd0);
    end

    task automatic wait_rsp(string req);
        int n;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, "response arrived", 64'(rsp_valid), 64'd1);
    endtask

    task automatic access(logic [31:0] a, string req);
        logic [3:0] c;
        bit h;
        c = exp_cand(a);
        h = model_hit(a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(req, "bank_en", 64'(bank_en), 64'(c));
        @(negedge clk);
        req_valid = 1'b0;
        if (h) begin
            chk(req, "hit valid", 64'(rsp_valid), 64'd1);
            chk(req, "hit flag", 64'(rsp_hit), 64'd1);
            chk(req, "hit data", 64'(rsp_data), 64'(mem_word(a)));
        end else begin
            chk(req, "ready after miss", 64'(req_ready), 64'd0);
            chk(req, "fill strobe", 64'(fill_req), 64'd1);
            wait_rsp(req);
            chk(req, "miss flag", 64'(rsp_hit), 64'd0);
            chk(req, "miss data", 64'(rsp_data), 64'(mem_word(a)));
            chk(req, "fill address", 64'(last_fill), 64'({a[31:5], 5'b0}));
            model_alloc(a);
        end
    endtask

    task automatic set_cfg(int m, logic [3:0] on);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_mode    = 2'(m);
        cfg_bank_on = on;
        #1;
        chk("R8", "ready during cfg write", 64'(req_ready), 64'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        mmode  = (m >= 2) ? 2 : m;
        mon    = on;
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 64; s++) mv[b][s] = 0;
        for (int s = 0; s < 64; s++) mrr[s] = 0;
    endtask

    // request held across a fill (R9): a misses, b shares its line
    task automatic overlap(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_addr = b;
        chk("R9", "ready right after miss", 64'(req_ready), 64'd0);
        wait_rsp("R9");
        chk("R9", "first miss flag", 64'(rsp_hit), 64'd0);
        chk("R9", "first miss data", 64'(rsp_data), 64'(mem_word(a)));
        chk("R9", "ready after fill", 64'(req_ready), 64'd1);
        model_alloc(a);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "held request valid", 64'(rsp_valid), 64'd1);
        chk("R9", "held request hit", 64'(rsp_hit), 64'(model_hit(b)));
        chk("R9", "held request data", 64'(rsp_data), 64'(mem_word(b)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 64; s++) mv[b][s] = 0;
        for (int s = 0; s < 64; s++) mrr[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "ready", 64'(req_ready), 64'd1);
        chk("R10", "fill_req", 64'(fill_req), 64'd0);
        chk("R10", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10", "bank_en", 64'(bank_en), 64'd0);

        // R1 four-way, R4 misses, R5 hits, R6 round robin
        access(32'h0000_0060, "R1");
        access(32'h0000_0868, "R1");
        access(32'h0000_1070, "R4");
        access(32'h0000_187C, "R4");
        access(32'h0000_0064, "R5");
        access(32'h0000_087C, "R5");
        access(32'h0000_1060, "R5");
        access(32'h0000_1864, "R1");
        access(32'h0000_2060, "R6");
        access(32'h0000_0060, "R6");
        access(32'h0000_1060, "R6");
        access(32'h0000_00FC, "R4");
        access(32'h0000_00E0, "R5");

        // R8 config write empties the cache; R2 two-way
        set_cfg(1, 4'hF);
        access(32'h0000_1060, "R8");
        access(32'h0000_0860, "R2");
        access(32'h0000_2860, "R2");
        access(32'h0000_4860, "R2");
        access(32'h0000_0860, "R2");
        access(32'h0000_4864, "R2");
        access(32'h0000_1068, "R2");

        // R3 one-way, including code 3
        set_cfg(2, 4'hF);
        access(32'h0000_0060, "R3");
        access(32'h0000_1860, "R3");
        access(32'h0000_2060, "R3");
        access(32'h0000_0060, "R3");
        access(32'h0000_1864, "R3");
        set_cfg(3, 4'hF);
        access(32'h0000_0860, "R3");
        access(32'h0000_0864, "R3");

        // R7 banks switched off
        set_cfg(0, 4'b0011);
        access(32'h0000_0060, "R7");
        access(32'h0000_0860, "R7");
        access(32'h0000_1060, "R7");
        access(32'h0000_0060, "R7");
        access(32'h0000_1064, "R7");
        set_cfg(2, 4'b0111);
        access(32'h0000_1860, "R7");
        access(32'h0000_1860, "R7");
        access(32'h0000_1060, "R7");
        access(32'h0000_1064, "R7");

        // R9 request held across a fill
        set_cfg(0, 4'hF);
        overlap(32'h0000_4420, 32'h0000_443C);
        overlap(32'h0000_5404, 32'h0000_5400);

        repeat (3) @(negedge clk);
        report();
    end
endmodule